// File: doc/BRIEF.md
# Fs-position data link receiver

This block sits behind a T1 framer that runs in twelve-frame superframe mode and has already found Ft alignment. For every frame the framer gives it a strobe, the framing bit, and a flag that tells whether the frame is a terminal-framing (Ft) position or a signalling-framing (Fs) position. Six superframes make a 72-frame multiframe. Its 36 Fs positions carry a 12-bit synchronization word followed by 24 message bits. Those message bits hold concentrator, maintenance, alarm and protection-switch fields.

The receiver ignores Ft positions. It hunts through the Fs bits for the synchronization word. When the word is found it raises a sticky match flag and collects the next 24 Fs bits. It delivers them as three bytes through one read register. Each byte has a full flag and a position index. If a byte is not read before the next one lands, an overrun flag is set. After each message the next 12 Fs bits are checked against the word again. Any mismatch drops the block back to hunting. The bit stream is never byte-destuffed, and there is no programmable match byte.

Top module: `fsdl_rx`

## Requirements
- R1: After reset, `match_flag`, `locked`, `dl_full` and `dl_ovr` are all 0.
- R2: A strobe with `fr_is_fs` = 0 (an Ft position) has no effect on hunting, collection or any output, whatever its bit value.
- R3: While hunting, `match_flag` and `locked` go to 1 at the clock edge that samples an Fs bit completing 12 consecutive Fs bits equal to `SYNC_PAT` (default 12'b000111000111, first-received bit = MSB). At least 12 Fs bits must have been taken since reset or the last loss of lock, and no earlier bit raises it.
- R4: `match_flag` stays at 1 until `stat_clr` is pulsed. A new match in the same cycle as `stat_clr` leaves it at 1.
- R5: After a match, the next 24 Fs bits are packed MSB first in arrival order into three bytes. These are presented in `dl_byte` with `dl_idx` = 0, 1, 2 in that order.
- R6: `dl_full` goes to 1 at the edge that samples the eighth bit of a byte. A `dl_rd` pulse clears it on the next edge.
- R7: If a byte completes while `dl_full` is still 1 and no read is made in that cycle, `dl_ovr` goes to 1 and the new byte replaces the old one. `stat_clr` clears `dl_ovr`.
- R8: After the 24 message bits, the next 12 Fs bits are compared with `SYNC_PAT`. If all agree, `match_flag` is set again, `locked` stays 1, and the next message is collected without hunting.
- R9: A single disagreeing bit during that comparison clears `locked` at once. No byte is delivered until a fresh 12-bit match has been made from new Fs bits.
- R10: Fs bits in message positions never raise `match_flag`, even when they equal the synchronization word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_stb | input | 1 | One-cycle strobe per received frame |
| fr_is_fs | input | 1 | 1 when the strobed frame is an Fs position, 0 for Ft |
| fr_bit | input | 1 | Framing bit of the strobed frame |
| stat_clr | input | 1 | Clears the match and overrun flags |
| dl_rd | input | 1 | Read of the data byte; clears the full flag |
| match_flag | output | 1 | Sticky synchronization-word match |
| locked | output | 1 | 1 while aligned to the multiframe |
| dl_byte | output | 8 | Most recently completed message byte |
| dl_idx | output | 2 | Position 0..2 of that byte in the message |
| dl_full | output | 1 | An unread byte is present |
| dl_ovr | output | 1 | A byte was overwritten before being read |

## Verification
The bench puts a run of ones in front of the synchronization word and samples one bit before the word completes. This separates a true 12-bit window match from a match on a shorter or stale window. The first message is itself a repetition of the word, which shows whether message positions are kept out of the hunt. Later messages use unlike byte values, which expose errors in bit order and byte index. A verification word corrupted in its fourth bit, followed by eight more bits, shows that lock is lost and no byte is delivered. A final message is sent with reads withheld, which tells a correct overrun and overwrite apart from a silent drop. Throughout, every Ft bit is the inverse of its Fs bit, so any leakage of Ft positions would corrupt the results.

// File: rtl/fsdl_pkg.sv
package fsdl_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_VERIFY  = 2'd2
    } hunt_state_e;

    // per-Fs-bit events from the aligner to the rest of the block
    typedef struct packed {
        logic msg_vld;
        logic msg_bit;
        logic match;
        logic drop;
    } hunt_evt_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fsdl_hunt.sv
module fsdl_hunt
    import fsdl_pkg::*;
#(
    parameter int               PAT_W    = 12,
    parameter int               MSG_BITS = 24,
    parameter logic [PAT_W-1:0] SYNC_PAT = 12'b000111000111
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fs_stb,
    input  logic      fs_bit,
    output hunt_evt_t evt,
    output logic      locked
);
    localparam int             CW       = cw(imax(PAT_W, MSG_BITS));
    localparam logic [CW-1:0]  PAT_LAST = CW'(PAT_W - 1);
    localparam logic [CW-1:0]  MSG_LAST = CW'(MSG_BITS - 1);

    hunt_state_e      st;
    logic [PAT_W-1:0] win;
    logic [CW-1:0]    fill;
    logic [CW-1:0]    cnt;
    logic [PAT_W-1:0] win_nx;
    logic             exp_bit;

    assign win_nx  = {win[PAT_W-2:0], fs_bit};
    assign exp_bit = SYNC_PAT[PAT_LAST - cnt];
    assign locked  = (st != ST_HUNT);

    always_comb begin
        evt = '0;
        if (fs_stb) begin
            case (st)
                ST_HUNT:    evt.match = (fill == PAT_LAST) && (win_nx == SYNC_PAT);
                ST_COLLECT: begin
                    evt.msg_vld = 1'b1;
                    evt.msg_bit = fs_bit;
                end
                ST_VERIFY: begin
                    if (fs_bit != exp_bit) evt.drop  = 1'b1;
                    else                   evt.match = (cnt == PAT_LAST);
                end
                default: evt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_HUNT;
            win  <= '0;
            fill <= '0;
            cnt  <= '0;
        end else if (fs_stb) begin
            case (st)
                ST_HUNT: begin
                    win <= win_nx;
                    if (fill != PAT_LAST) fill <= fill + 1'b1;
                    if (evt.match) begin
                        st  <= ST_COLLECT;
                        cnt <= '0;
                    end
                end
                ST_COLLECT: begin
                    if (cnt == MSG_LAST) begin
                        st  <= ST_VERIFY;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (evt.drop) begin
                        st   <= ST_HUNT;
                        win  <= '0;
                        fill <= '0;
                        cnt  <= '0;
                    end else if (evt.match) begin
                        st  <= ST_COLLECT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_HUNT;
            endcase
        end
    end

    // R2: no Fs strobe (Ft or idle) leaves alignment untouched
    assert_ft_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        !fs_stb |=> ($stable(st) && $stable(win) && $stable(cnt)));

    // R9: a mismatch while verifying ends lock on the next edge
    assert_drop_unlocks_R9: assert property (@(posedge clk) disable iff (rst)
        evt.drop |=> !locked);

    // R10: message positions never produce a match event
    assert_no_match_in_msg_R10: assert property (@(posedge clk) disable iff (rst)
        evt.msg_vld |-> !evt.match);

endmodule

// File: rtl/fsdl_pack.sv
module fsdl_pack
    import fsdl_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_vld,
    input  logic                    bit_in,
    input  logic                    restart,
    input  logic                    rd,
    input  logic                    ovr_clr,
    output logic [BYTE_W-1:0]       byte_q,
    output logic [cw(NBYTES)-1:0]   idx_q,
    output logic                    full,
    output logic                    ovr
);
    localparam int                BCW       = cw(BYTE_W);
    localparam int                IW        = cw(NBYTES);
    localparam logic [BCW-1:0]    BIT_LAST  = BCW'(BYTE_W - 1);
    localparam logic [IW-1:0]     SLOT_LAST = IW'(NBYTES - 1);

    logic [BYTE_W-1:0] sh;
    logic [BCW-1:0]    bcnt;
    logic [IW-1:0]     slot;
    logic              byte_done;

    assign byte_done = bit_vld && (bcnt == BIT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            bcnt   <= '0;
            slot   <= '0;
            byte_q <= '0;
            idx_q  <= '0;
        end else if (restart) begin
            bcnt <= '0;
            slot <= '0;
        end else if (bit_vld) begin
            sh <= {sh[BYTE_W-2:0], bit_in};
            if (byte_done) begin
                byte_q <= {sh[BYTE_W-2:0], bit_in};
                idx_q  <= slot;
                slot   <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
                bcnt   <= '0;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (byte_done)  full <= 1'b1;
            else if (rd)    full <= 1'b0;
            if (byte_done && full && !rd) ovr <= 1'b1;
            else if (ovr_clr)             ovr <= 1'b0;
        end
    end

    // R6: a byte becomes full only on an accepted message bit
    assert_full_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(bit_vld));

    // R6: a read with no completing byte empties the register
    assert_rd_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && full && !bit_vld) |=> !full);

    // R7: overrun needs an unread byte already held
    assert_ovr_src_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(full));

endmodule

// File: rtl/fsdl_rx.sv
module fsdl_rx
    import fsdl_pkg::*;
#(
    parameter int          PAT_W    = 12,
    parameter int          BYTE_W   = 8,
    parameter int          NBYTES   = 3,
    parameter logic [11:0] SYNC_PAT = 12'b000111000111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fr_stb,
    input  logic              fr_is_fs,
    input  logic              fr_bit,
    input  logic              stat_clr,
    input  logic              dl_rd,
    output logic              match_flag,
    output logic              locked,
    output logic [BYTE_W-1:0] dl_byte,
    output logic [1:0]        dl_idx,
    output logic              dl_full,
    output logic              dl_ovr
);
    localparam int MSG_BITS = BYTE_W * NBYTES;
    localparam int IW       = cw(NBYTES);

    hunt_evt_t     evt;
    logic          fs_stb;
    logic [IW-1:0] idx_w;

    assign fs_stb = fr_stb && fr_is_fs;

    fsdl_hunt #(
        .PAT_W    (PAT_W),
        .MSG_BITS (MSG_BITS),
        .SYNC_PAT (PAT_W'(SYNC_PAT))
    ) u_hunt (
        .clk    (clk),
        .rst    (rst),
        .fs_stb (fs_stb),
        .fs_bit (fr_bit),
        .evt    (evt),
        .locked (locked)
    );

    fsdl_pack #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_pack (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (evt.msg_vld),
        .bit_in  (evt.msg_bit),
        .restart (evt.match || evt.drop),
        .rd      (dl_rd),
        .ovr_clr (stat_clr),
        .byte_q  (dl_byte),
        .idx_q   (idx_w),
        .full    (dl_full),
        .ovr     (dl_ovr)
    );

    assign dl_idx = 2'(idx_w);

    always_ff @(posedge clk) begin
        if (rst)            match_flag <= 1'b0;
        else if (evt.match) match_flag <= 1'b1;
        else if (stat_clr)  match_flag <= 1'b0;
    end

    // R3: the flag can only rise on a sampled Fs position
    assert_match_on_fs_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(match_flag) |-> $past(fr_stb && fr_is_fs));

    // R4: the flag holds until a clear is seen
    assert_match_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !stat_clr) |=> match_flag);

    // R9: gaining lock always comes with a match
    assert_lock_needs_match_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> match_flag);

endmodule

// File: tb/fsdl_rx_bench.sv
module fsdl_rx_bench;
    localparam logic [11:0] PAT = 12'b000111000111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fr_stb = 1'b0, fr_is_fs = 1'b0, fr_bit = 1'b0;
    logic       stat_clr = 1'b0;
    logic       mon_rd = 1'b0, man_rd = 1'b0;
    logic       dl_rd;
    logic       match_flag, locked, dl_full, dl_ovr;
    logic [7:0] dl_byte;
    logic [1:0] dl_idx;

    int  checks = 0;
    int  errors = 0;
    bit  auto_rd = 1'b1;
    bit  done = 1'b0;
    logic [9:0] exp_q[$];

    assign dl_rd = mon_rd | man_rd;

    always #5 clk = ~clk;

    fsdl_rx u_fsdl_rx (
        .clk(clk), .rst(rst), .fr_stb(fr_stb), .fr_is_fs(fr_is_fs), .fr_bit(fr_bit),
        .stat_clr(stat_clr), .dl_rd(dl_rd), .match_flag(match_flag), .locked(locked),
        .dl_byte(dl_byte), .dl_idx(dl_idx), .dl_full(dl_full), .dl_ovr(dl_ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one Ft frame (inverted bit, R2) then one Fs frame
    task automatic fs_frame(input logic b);
        @(negedge clk); fr_stb = 1'b1; fr_is_fs = 1'b0; fr_bit = ~b;
        @(negedge clk); fr_stb = 1'b1; fr_is_fs = 1'b1; fr_bit = b;
        @(negedge clk); fr_stb = 1'b0; fr_is_fs = 1'b0; fr_bit = 1'b0;
    endtask

    task automatic send_bits(input logic [23:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) fs_frame(v[i]);
    endtask

    task automatic send_msg(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        if (auto_rd) begin
            exp_q.push_back({2'd0, b0});
            exp_q.push_back({2'd1, b1});
            exp_q.push_back({2'd2, b2});
        end
        send_bits({b0, b1, b2}, 24);
    endtask

    task automatic pulse_clr();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    // monitor: scoreboard compare of every delivered byte (R5, R6)
    initial begin
        forever begin
            @(negedge clk);
            if (mon_rd) mon_rd = 1'b0;
            else if (auto_rd && dl_full) begin
                if (exp_q.size() == 0) chk("R5 unexpected byte", {22'd0, dl_idx, dl_byte}, 32'h3ff);
                else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk("R5 byte/index", {22'd0, dl_idx, dl_byte}, {22'd0, e});
                end
                mon_rd = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 match", match_flag, 0);
        chk("R1 locked", locked, 0);
        chk("R1 full", dl_full, 0);
        chk("R1 ovr", dl_ovr, 0);

        // R3: junk prefix, then pattern; not before the twelfth bit
        send_bits(24'h1f, 5);
        send_bits({12'd0, PAT} >> 1, 11);
        chk("R3 no early match", match_flag, 0);
        chk("R2 Ft ignored, not locked", locked, 0);
        fs_frame(PAT[0]);
        chk("R3 match", match_flag, 1);
        chk("R3 locked", locked, 1);

        // R4 stickiness then clear; R10 message equals the word
        send_msg(8'h1c, 8'h71, 8'hc7);
        chk("R4 sticky", match_flag, 1);
        pulse_clr();
        chk("R4 cleared", match_flag, 0);
        chk("R10 no match from message", match_flag, 0);

        // R8: good verify word
        send_bits({12'd0, PAT}, 12);
        chk("R8 rematch", match_flag, 1);
        chk("R8 locked", locked, 1);
        send_msg(8'ha5, 8'h3c, 8'h0f);
        pulse_clr();

        // R9: corrupted verify word (fourth bit wrong)
        send_bits({21'd0, PAT[11:9]}, 3);
        fs_frame(~PAT[8]);
        chk("R9 unlocked", locked, 0);
        send_bits(24'haa, 8);
        repeat (2) @(negedge clk);
        chk("R9 no byte", dl_full, 0);
        chk("R9 no match", match_flag, 0);
        chk("R5 queue drained", exp_q.size(), 0);

        // resync, then R7 overrun with reads withheld
        send_bits({12'd0, PAT}, 12);
        chk("R3 relock", locked, 1);
        auto_rd = 1'b0;
        send_msg(8'h11, 8'h22, 8'h33);
        chk("R7 ovr", dl_ovr, 1);
        chk("R7 newest byte", dl_byte, 8'h33);
        chk("R7 newest idx", dl_idx, 2);
        chk("R6 full held", dl_full, 1);
        @(negedge clk); man_rd = 1'b1;
        @(negedge clk); man_rd = 1'b0;
        chk("R6 read clears", dl_full, 0);
        pulse_clr();
        chk("R7 ovr cleared", dl_ovr, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule